// File: doc/BRIEF.md
# I2C Slave with Four Programmable Addresses

This block is the target side of an I2C bus. It watches the synchronized clock and data lines, collects the 7-bit address and read/write bit that follow every Start condition, and compares the address with four programmable entries. Each entry can be enabled or disabled. When an enabled entry matches, the slave selects itself and reports which entry matched. At the next low phase of the clock it then raises a pending flag with a state code that tells software what to do. The block does not acknowledge anything on its own.

While the flag is pending, the slave holds the clock line low through its open-drain output, so the master waits. Software answers with a Continue pulse or a NACK pulse. Either pulse releases the clock. In the address state (code 0) and the receive state (code 1), Continue acknowledges and NACK refuses. In the transmit state (code 2), Continue loads the byte on the transmit data input and shifts it out, MSB first. A NACK from the master on a transmitted byte ends the selection. A DMA request is raised only while a data state (code 1 or 2) is pending.

Top module: `i2c_quad_addr_slave`

## Requirements
- R1: After reset, both open-drain enables are 0 and pending, selected and dma_req are 0.
- R2: An address byte whose upper 7 bits equal an enabled entry (entry i: bits 8i+6..8i address, bit 8i+7 enable) selects the slave. After the falling clock edge that ends the 8th bit, pending is 1 with code 0 and match_idx set to i. When several entries match, the lowest index wins.
- R3: An address that matches no enabled entry (disabled entries never match) leaves pending and selected at 0 and never drives SDA. While deselected, sda_oe stays 0.
- R4: While pending, scl_oe holds the clock low. It is 0 whenever pending is 0. A Continue or NACK pulse clears pending on the next cycle.
- R5: In codes 0 and 1, Continue drives SDA low during the acknowledge clock. NACK leaves SDA released and deselects the slave at the end of that clock.
- R6: In a write transfer, the 8 bits after an acknowledged byte are collected MSB first into rx_data, and pending rises with code 1.
- R7: In a read transfer, an acknowledged address gives code 2 pending. Continue then drives tx_data out MSB first, with sda_oe equal to the inverse of each bit.
- R8: A master ACK after a transmitted byte gives code 2 pending again. A master NACK deselects the slave with pending 0 and SDA released.
- R9: dma_req is 1 only while pending with code 1 or 2. It is 0 while pending with code 0, and 0 when nothing is pending.
- R10: A Stop, or a Repeated Start followed by a non-matching address, deselects the slave and clears pending.
- R11: Continue and NACK pulses have no effect while pending is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| scl_oe | output | 1 | 1 pulls SCL low (stretching) |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_tbl | input | 8*NUM_ADDR | Per entry: enable in bit 7, address in bits 6..0 |
| cmd_go | input | 1 | Continue command pulse |
| cmd_nack | input | 1 | NACK command pulse |
| tx_data | input | 8 | Byte loaded by Continue in code 2 |
| rx_data | output | 8 | Last received data byte |
| pending | output | 1 | Software action awaited |
| slv_code | output | 2 | 0 address, 1 data received, 2 data to send |
| match_idx | output | $clog2(NUM_ADDR) | Index of the matched entry |
| selected | output | 1 | Slave is addressed |
| dma_req | output | 1 | Data transfer request |

## Verification
The bench walks a set of addresses that covers a hit on each enabled entry, a disabled entry, and near misses that differ by one bit. A comparator that ignored the enable bit, or that took the read/write bit as part of the address, would acknowledge or flag the wrong byte. Directed transfers check that a NACK in the address or receive state leaves SDA high. They also check that a master NACK ends a read, and that a Repeated Start to a foreign address drops a selection that was live. A design that forgot to deselect would keep pulling SDA or raise pending on traffic meant for another target. Duplicate entries and command pulses sent while idle check the priority order and that stray pulses do nothing.

// File: rtl/i2c_quad_addr_slave.sv
module i2c_quad_addr_slave #(
  parameter int NUM_ADDR = 4,
  localparam int IDXW = $clog2(NUM_ADDR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  scl_oe,
  output logic                  sda_oe,
  input  logic [8*NUM_ADDR-1:0] addr_tbl,
  input  logic                  cmd_go,
  input  logic                  cmd_nack,
  input  logic [7:0]            tx_data,
  output logic [7:0]            rx_data,
  output logic                  pending,
  output logic [1:0]            slv_code,
  output logic [IDXW-1:0]       match_idx,
  output logic                  selected,
  output logic                  dma_req
);

  typedef enum logic [2:0] {
    P_IDLE, P_ADDR, P_ENDB, P_HOLD, P_ACK, P_RX, P_TX, P_MACK
  } phase_t;

  phase_t       phase;
  logic         scl_q, sda_q, rw, ack_q;
  logic [2:0]   bitcnt;
  logic [7:0]   shreg;
  logic         hit;
  logic [IDXW-1:0] hit_idx;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire [7:0] in_byte = {shreg[6:0], sda_i};

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NUM_ADDR - 1; i >= 0; i--) begin
      if (addr_tbl[8*i+7] && addr_tbl[8*i +: 7] == in_byte[7:1]) begin
        hit = 1'b1;
        hit_idx = i[IDXW-1:0];
      end
    end
  end

  assign scl_oe  = (phase == P_HOLD);
  assign sda_oe  = ((phase == P_ACK) & ack_q) | ((phase == P_TX) & ~shreg[7]);
  assign dma_req = pending & (slv_code != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      rw        <= 1'b0;
      ack_q     <= 1'b0;
      bitcnt    <= '0;
      shreg     <= '0;
      rx_data   <= '0;
      pending   <= 1'b0;
      slv_code  <= 2'd0;
      match_idx <= '0;
      selected  <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (stop_c) begin
        phase    <= P_IDLE;
        selected <= 1'b0;
        pending  <= 1'b0;
      end else if (start_c) begin
        phase    <= P_ADDR;
        bitcnt   <= '0;
        selected <= 1'b0;
        pending  <= 1'b0;
      end else begin
        case (phase)
          P_ADDR: if (scl_rise) begin
            shreg  <= in_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (hit) begin
                selected  <= 1'b1;
                match_idx <= hit_idx;
                rw        <= sda_i;
                slv_code  <= 2'd0;
                phase     <= P_ENDB;
              end else begin
                phase <= P_IDLE;
              end
            end
          end
          P_RX: if (scl_rise) begin
            shreg  <= in_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              rx_data  <= in_byte;
              slv_code <= 2'd1;
              phase    <= P_ENDB;
            end
          end
          P_ENDB: if (scl_fall) begin
            pending <= 1'b1;
            phase   <= P_HOLD;
          end
          P_HOLD: if (cmd_go) begin
            pending <= 1'b0;
            bitcnt  <= '0;
            if (slv_code == 2'd2) begin
              shreg <= tx_data;
              phase <= P_TX;
            end else begin
              ack_q <= 1'b1;
              phase <= P_ACK;
            end
          end else if (cmd_nack) begin
            pending <= 1'b0;
            if (slv_code == 2'd2) begin
              selected <= 1'b0;
              phase    <= P_IDLE;
            end else begin
              ack_q <= 1'b0;
              phase <= P_ACK;
            end
          end
          P_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (!ack_q) begin
              selected <= 1'b0;
              phase    <= P_IDLE;
            end else if (slv_code == 2'd0 && rw) begin
              slv_code <= 2'd2;
              pending  <= 1'b1;
              phase    <= P_HOLD;
            end else begin
              phase <= P_RX;
            end
          end
          P_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              phase <= P_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b1};
              bitcnt <= bitcnt + 3'd1;
            end
          end
          P_MACK: if (scl_rise) begin
            if (sda_i) begin
              selected <= 1'b0;
              phase    <= P_IDLE;
            end else begin
              slv_code <= 2'd2;
              phase    <= P_ENDB;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_quad_addr_slave_chk #(
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            scl_oe,
  input logic            sda_oe,
  input logic            cmd_go,
  input logic            cmd_nack,
  input logic            pending,
  input logic [1:0]      slv_code,
  input logic [IDXW-1:0] match_idx,
  input logic            selected,
  input logic            dma_req
);

  AST_STRETCH_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !scl_i |-> scl_oe); // R4
  AST_NO_STRETCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !scl_oe); // R4
  AST_CMD_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pending && (cmd_go || cmd_nack) |=> !pending); // R4
  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> !sda_oe); // R3
  AST_PENDING_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> selected); // R10
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> $stable(match_idx)); // R2
  AST_NO_DMA_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    pending && slv_code == 2'd0 |-> !dma_req); // R9
  AST_NO_DMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> !dma_req); // R9

endmodule

bind i2c_quad_addr_slave i2c_quad_addr_slave_chk #(.IDXW(2)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .cmd_go(cmd_go), .cmd_nack(cmd_nack), .pending(pending), .slv_code(slv_code),
  .match_idx(match_idx), .selected(selected), .dma_req(dma_req)
);

// File: tb/test_i2c_quad_addr_slave.sv
`timescale 1ns/1ps
module test_i2c_quad_addr_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic [31:0] addr_tbl = {8'hEA, 8'h40, 8'hB5, 8'hA1};
  logic cmd_go = 1'b0, cmd_nack = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic pending, selected, dma_req;
  logic [1:0] slv_code, match_idx;
  int n_cmp = 0, n_bad = 0;

  wire scl_i = scl_m & ~scl_oe;
  wire sda_i = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_quad_addr_slave i_i2c_quad_addr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_tbl(addr_tbl),
    .cmd_go(cmd_go), .cmd_nack(cmd_nack), .tx_data(tx_data),
    .rx_data(rx_data), .pending(pending), .slv_code(slv_code),
    .match_idx(match_idx), .selected(selected), .dma_req(dma_req)
  );

  // {address[6:0], rw, hit, index[1:0]}
  localparam logic [10:0] VEC [8] = '{
    {7'h21, 1'b0, 1'b1, 2'd0}, {7'h35, 1'b0, 1'b1, 2'd1},
    {7'h40, 1'b0, 1'b0, 2'd0}, {7'h6A, 1'b1, 1'b1, 2'd3},
    {7'h22, 1'b0, 1'b0, 2'd0}, {7'h35, 1'b1, 1'b1, 2'd1},
    {7'h6A, 1'b0, 1'b1, 2'd3}, {7'h20, 1'b1, 1'b0, 2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic rise_scl();
    scl_m = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (scl_i) break;
    end
    if (!scl_i) check("R4 clock stuck low", 0, 1);
  endtask

  task automatic start_c();
    sda_m = 1'b1; half(); rise_scl(); half();
    sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; half(); rise_scl(); half();
    sda_m = 1'b1; half();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; half(); rise_scl(); half(); scl_m = 1'b0; half();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; half(); rise_scl(); half(); b = sda_i; scl_m = 1'b0; half();
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) put_bit(v[k]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int k = 7; k >= 0; k--) begin get_bit(b); v[k] = b; end
  endtask

  task automatic pulse(input logic go);
    if (go) cmd_go = 1'b1; else cmd_nack = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0; cmd_nack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic b;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    check("R1 scl_oe", scl_oe, 0); check("R1 sda_oe", sda_oe, 0);
    check("R1 pending", pending, 0); check("R1 selected", selected, 0);
    check("R1 dma_req", dma_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    pulse(1'b1); pulse(1'b0);
    check("R11 pending", pending, 0); check("R11 sda_oe", sda_oe, 0);
    check("R11 scl_oe", scl_oe, 0);

    foreach (VEC[n]) begin
      start_c();
      put_byte(VEC[n][10:3]);
      check("R2/R3 pending", pending, VEC[n][2]);
      check("R2/R3 selected", selected, VEC[n][2]);
      if (VEC[n][2]) begin
        check("R2 code", slv_code, 0); check("R2 idx", match_idx, VEC[n][1:0]);
        check("R9 dma in code 0", dma_req, 0); check("R4 stretch", scl_oe, 1);
        pulse(1'b0);
        check("R4 cleared", pending, 0);
        get_bit(b); check("R5 nack bit", b, 1);
      end else begin
        get_bit(b); check("R3 no ack", b, 1);
      end
      check("R5/R3 deselected", selected, 0);
      stop_c();
    end

    // write transfer
    start_c(); put_byte({7'h21, 1'b0}); pulse(1'b1);
    get_bit(b); check("R5 ack bit", b, 0);
    put_byte(8'hA5);
    check("R6 pending", pending, 1); check("R6 code", slv_code, 1);
    check("R6 rx", rx_data, 8'hA5); check("R9 dma rx", dma_req, 1);
    check("R4 stretch rx", scl_oe, 1);
    pulse(1'b1); get_bit(b); check("R5 data ack", b, 0);
    put_byte(8'h3C); check("R6 rx2", rx_data, 8'h3C);
    pulse(1'b0); get_bit(b); check("R5 data nack", b, 1);
    check("R5 deselect", selected, 0); check("R5 pending", pending, 0);
    stop_c();

    // read transfer
    start_c(); put_byte({7'h35, 1'b1}); pulse(1'b1);
    get_bit(b); check("R5 read addr ack", b, 0);
    check("R7 pending", pending, 1); check("R7 code", slv_code, 2);
    check("R9 dma tx", dma_req, 1);
    tx_data = 8'hC3; pulse(1'b1);
    get_byte(v); check("R7 tx byte", v, 8'hC3);
    put_bit(1'b0);
    check("R8 pending again", pending, 1); check("R8 code", slv_code, 2);
    tx_data = 8'h5A; pulse(1'b1);
    get_byte(v); check("R7 tx byte2", v, 8'h5A);
    put_bit(1'b1);
    check("R8 deselect", selected, 0); check("R8 pending", pending, 0);
    check("R8 sda released", sda_oe, 0);
    stop_c();

    // stop after acknowledged address
    start_c(); put_byte({7'h6A, 1'b0}); pulse(1'b1); get_bit(b);
    check("R10 selected before stop", selected, 1);
    stop_c(); check("R10 stop deselect", selected, 0);

    // repeated start to foreign address
    start_c(); put_byte({7'h21, 1'b0}); pulse(1'b1); get_bit(b);
    start_c(); put_byte({7'h22, 1'b0});
    check("R10 rs pending", pending, 0); check("R10 rs selected", selected, 0);
    get_bit(b); check("R10 rs no ack", b, 1);
    stop_c();

    // enabling entry 2, then duplicate of entry 0 in entry 3
    addr_tbl = {8'hEA, 8'hC0, 8'hB5, 8'hA1};
    start_c(); put_byte({7'h40, 1'b0});
    check("R3 enabled entry hit", pending, 1); check("R2 idx 2", match_idx, 2);
    pulse(1'b0); get_bit(b); stop_c();
    addr_tbl = {8'hA1, 8'h40, 8'hB5, 8'hA1};
    start_c(); put_byte({7'h21, 1'b0});
    check("R2 lowest index", match_idx, 0);
    pulse(1'b0); get_bit(b); stop_c();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule